// File: doc/BRIEF.md
# Packed Monochrome Frame Scanout

This block turns a one-bit-per-pixel frame image, stored sixteen pixels to a 16-bit word in a synchronous RAM, into a continuous stream of 24-bit colors at one pixel per clock. It drives the RAM read address itself and takes the word back from a read port that has one clock of registered latency. A video timing generator supplies a frame-start pulse during vertical blanking and an active-video strobe. Pixels are consumed only while that strobe is high, so the image is drawn in the same place on every frame.

The word address is forced back to zero on every frame-start pulse. The next word is requested while the current one is still being shifted out. A word is taken from the RAM data port on the clock of its first pixel and its remaining fifteen bits come from an internal shift register. Every word therefore lasts exactly sixteen active clocks, with no gap between words. The color output is registered, and it follows the active-video strobe by exactly one clock. The timing generator must delay its syncs by that one clock to match.

Top module: `mono_scanout`

## Requirements
- R1: Within a word, pixels leave least-significant bit first: the n-th active pixel of a word (n = 0..15) is bit n of that word.
- R2: Consecutive words follow each other with no idle cycle: 16 active clocks consume exactly one word, and the next active clock shows bit 0 of the next word.
- R3: After the last word of the frame (address FRAME_WORDS-1) the read address wraps to 0 without needing a frame-start pulse.
- R4: A frame-start pulse resets the stream so the next active pixel is bit 0 of word 0, and `rd_addr` reads 0 on the clock after the pulse.
- R5: While `active_in` is low, neither the read address nor the position inside the current word moves. A line may end in the middle of a word and the next line carries on from the following bit.
- R6: A pixel bit of 0 is output as green (24'h00FF00) and a bit of 1 as blue (24'h0000FF). The byte order is red, green, blue, from bit 23 down to bit 0.
- R7: On any clock after one where `active_in` was low, `rgb_out` is black (24'h000000).
- R8: While `rst_n` is low at a clock edge (synchronous, active low, tied to PLL lock), `rd_addr` becomes 0, `rgb_out` becomes black, and the stream restarts at bit 0 of word 0.
- R9: `rgb_out` shows the color of a pixel exactly one clock after the edge at which `active_in` was sampled high for it.
- R10: `rd_addr` moves to the next word on the first active pixel of the current word. The data port must return mem[addr] one clock after the address is presented. A frame-start pulse must come at least two clocks before the first active pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset, low while the pixel PLL is unlocked |
| frame_start | input | 1 | One-clock pulse in vertical blanking that restarts the frame |
| active_in | input | 1 | Active-video strobe from the timing generator |
| rd_data | input | 16 | RAM read data, registered one clock after `rd_addr` |
| rd_addr | output | ADDR_W | RAM word read address |
| rgb_out | output | 24 | Registered pixel color, red in bits 23:16 |

## Verification
The bench uses lines of 20 pixels, which do not fill a whole number of words. A design that dropped its bit position during blanking, or that re-fetched a word at the start of each line, would show shifted pixels on the second line. A short frame with no frame-start pulse across the wrap catches an address that runs past the last word or that stalls there. A second frame-start in the middle of a frame catches a block that restarts only the address or only the bit count, since either mistake makes the image drift. The words in RAM include all-zeros, all-ones and mixed patterns, so a swapped bit order or a missing prefetch (which shows the previous word's bits) gives wrong colors at word boundaries.

// File: rtl/mono_scanout_pkg.sv
// Package: shared color type and fixed color values for the scanout path.
// Assumes 8 bits per channel, red in the top byte.
package mono_scanout_pkg;
    typedef logic [23:0] rgb_t;

    localparam rgb_t COLOR_BLACK = 24'h000000;
    localparam rgb_t COLOR_GREEN = 24'h00FF00;  // pixel bit 0
    localparam rgb_t COLOR_BLUE  = 24'h0000FF;  // pixel bit 1
endpackage

// File: rtl/mono_word_addr.sv
// mono_word_addr: word read-address counter for the packed frame.
// It holds the address of the word that will be needed next. Frame start
// forces it to 0, and each advance pulse moves it on, wrapping after the
// last word. It assumes advance comes on the first pixel of each word.
module mono_word_addr #(
    parameter int FRAME_WORDS = 81000,
    parameter int ADDR_W      = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(FRAME_WORDS - 1);

    // Purpose: restart on frame start, otherwise step and wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (frame_start) begin
            addr <= '0;
        end else if (advance) begin
            addr <= (addr == LAST_WORD) ? '0 : addr + ADDR_W'(1);
        end
    end

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && advance && addr == LAST_WORD) |=> (addr == '0));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (addr == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !advance) |=> $stable(addr));
endmodule

// File: rtl/mono_bit_unpack.sv
// mono_bit_unpack: turns 16-bit words into one bit per active clock.
// On the first pixel of a word, bit 0 comes straight from the RAM data
// port, and the upper bits are kept in a shift register that moves right
// on every later active clock. It assumes rd_data already holds the wanted
// word on the clock of that first pixel.
module mono_bit_unpack #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              active,
    input  logic [WORD_W-1:0] rd_data,
    output logic              pix_bit,
    output logic              word_take
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              first_bit;

    assign first_bit = (bit_cnt == '0);
    assign pix_bit   = first_bit ? rd_data[0] : shreg[0];
    assign word_take = active && first_bit && !frame_start;

    // Purpose: track the position inside the word, pausing in blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (frame_start) begin
            bit_cnt <= '0;
        end else if (active) begin
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + CNT_W'(1);
        end
    end

    // Purpose: capture the fresh word, or shift out the one in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (active) begin
            shreg <= first_bit ? (rd_data >> 1) : (shreg >> 1);
        end
    end

    assert_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !frame_start) |=> ($stable(bit_cnt) && $stable(shreg)));

    assert_restart_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (bit_cnt == '0));
endmodule

// File: rtl/mono_color_map.sv
// mono_color_map: registered map from a pixel bit to a 24-bit color.
// It gives black outside active video, green for 0 and blue for 1.
// This register is the single clock of pipeline latency in the block.
module mono_color_map
    import mono_scanout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic pix_bit,
    output rgb_t rgb
);
    // Purpose: register the color of the current pixel, black in blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb <= COLOR_BLACK;
        end else if (!active) begin
            rgb <= COLOR_BLACK;
        end else begin
            rgb <= pix_bit ? COLOR_BLUE : COLOR_GREEN;
        end
    end

    assert_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (rgb == COLOR_BLACK));

    assert_palette_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (rgb == COLOR_GREEN || rgb == COLOR_BLUE));

    assert_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (rgb == ($past(pix_bit) ? COLOR_BLUE : COLOR_GREEN)));
endmodule

// File: rtl/mono_scanout.sv
// mono_scanout: top of the packed monochrome frame scanout path.
// It fetches 16-pixel words ahead of use, unpacks them LSB first at one
// pixel per active clock, and outputs registered colors one clock after
// active_in. It assumes a RAM read port with one clock of latency, and a
// frame_start pulse at least two clocks before the first active pixel.
module mono_scanout
    import mono_scanout_pkg::*;
#(
    parameter int FRAME_WORDS = 81000,
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              active_in,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [23:0]       rgb_out
);
    logic pix_bit;
    logic word_take;
    rgb_t rgb_q;

    mono_bit_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .active     (active_in),
        .rd_data    (rd_data),
        .pix_bit    (pix_bit),
        .word_take  (word_take)
    );

    mono_word_addr #(.FRAME_WORDS(FRAME_WORDS), .ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .advance    (word_take),
        .addr       (rd_addr)
    );

    mono_color_map u_color (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active_in),
        .pix_bit(pix_bit),
        .rgb    (rgb_q)
    );

    assign rgb_out = rgb_q;

    // R10: the address leaves a word on that word's first active pixel.
    assert_prefetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_take) |=> (rd_addr != $past(rd_addr) || FRAME_WORDS == 1));
endmodule

// File: tb/sim_mono_scanout.sv
// Bench for mono_scanout: behavioural RAM plus a pixel-index reference
// model, with outputs compared on every falling edge.
module sim_mono_scanout;
    localparam int FW = 6;
    localparam int AW = $clog2(FW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          active_in = 1'b0;
    logic [15:0]   rd_data = 16'h0;
    logic [AW-1:0] rd_addr;
    logic [23:0]   rgb_out;

    logic [15:0] mem [FW];
    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    int    pidx   = 0;
    int    exp_addr = 0;
    logic [23:0] exp_rgb = 24'h0;
    string tag = "R8";
    bit    done = 1'b0;

    always #5 clk = ~clk;  // 100 MHz

    mono_scanout #(.FRAME_WORDS(FW), .WORD_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .active_in(active_in), .rd_data(rd_data),
        .rd_addr(rd_addr), .rgb_out(rgb_out)
    );

    // RAM read port with one clock of latency (R10)
    always @(posedge clk) rd_data <= mem[rd_addr];

    // Reference model: frame pixel index -> word, bit, color (R1, R2, R3, R6)
    always @(posedge clk) begin
        if (!rst_n) begin
            pidx = 0;
            exp_rgb <= 24'h000000;
        end else if (frame_start) begin
            pidx = 0;
            exp_rgb <= 24'h000000;
        end else if (active_in) begin
            exp_rgb <= mem[pidx / 16][pidx % 16] ? 24'h0000FF : 24'h00FF00;
            pidx = (pidx + 1) % (FW * 16);
        end else begin
            exp_rgb <= 24'h000000;  // R7
        end
        exp_addr <= (pidx % 16 == 0) ? pidx / 16 : (pidx / 16 + 1) % FW;
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rgb_out !== exp_rgb) begin
                errors++;
                $display("FAIL %s rgb_out: actual=%h expected=%h at cycle %0d",
                         tag, rgb_out, exp_rgb, cycles);
            end
            checks++;
            if (int'(rd_addr) != exp_addr) begin
                errors++;
                $display("FAIL %s rd_addr: actual=%0d expected=%0d at cycle %0d",
                         tag, rd_addr, exp_addr, cycles);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic drive(input bit fs, input bit act, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start = fs;
            active_in   = act;
        end
    endtask

    task automatic line(input int pix, input int blank);
        drive(1'b0, 1'b1, pix);
        drive(1'b0, 1'b0, blank);
    endtask

    initial begin
        for (int i = 0; i < FW; i++) mem[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
        mem[1] = 16'hFFFF;
        mem[2] = 16'h0000;
        mem[4] = 16'h8001;

        tag = "R8";  // reset state: address 0, black output
        drive(1'b0, 1'b0, 4);
        @(negedge clk) rst_n = 1'b1;
        drive(1'b0, 1'b0, 2);

        tag = "R4/R10";  // frame start, then at least two idle clocks
        drive(1'b1, 1'b0, 1);
        drive(1'b0, 1'b0, 2);

        tag = "R5/R1/R6/R9";  // 20-pixel lines split words across blanking
        for (int l = 0; l < 3; l++) line(20, 5);

        tag = "R4";  // restart in mid frame
        drive(1'b1, 1'b0, 1);
        drive(1'b0, 1'b0, 3);

        tag = "R2/R3";  // continuous run past the end of the frame
        line(FW * 16 + 40, 4);

        tag = "R8";  // reset in mid stream, then a fresh frame
        line(7, 0);
        @(negedge clk) rst_n = 1'b0;
        drive(1'b0, 1'b0, 2);
        @(negedge clk) rst_n = 1'b1;
        drive(1'b0, 1'b0, 2);
        tag = "R7/R1";
        drive(1'b1, 1'b0, 1);
        drive(1'b0, 1'b0, 2);
        for (int l = 0; l < 4; l++) line(33, 3);

        drive(1'b0, 1'b0, 3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule